// File: doc/BRIEF.md
# TDM Frame and Bit Clock Generator

This block derives the timing for a time-division multiplexed backplane from a 16.384 MHz master clock. An 11-bit frame counter wraps once every 2048 master cycles, which gives an 8 kHz frame. The low counter bits become 8.192, 4.096 and 2.048 MHz local clocks. A decode around the wrap point produces a frame pulse, plus an active-low frame strobe for the backplane.

The block has two modes. In free-running mode the counter simply wraps. In synchronized mode, a selected external 8 kHz reference is brought onto the master clock through a synchronizer and a rising-edge detector. Each detected edge moves the counter phase so that the frame boundary lines up with the reference. Because the edge is sampled on the master clock, the alignment is quantized to one master period, and that quantization is accepted as output jitter.

A small configuration register does three things. It sets the polarity of each local clock output. It holds the master-enable bit that drives the backplane output enable. It also lets software read back the synchronized levels of four input pins.

Top module: `tdm_clkgen`

## Requirements
- R1: While reset is held, the counter is 0. All local clock outputs are low, `frame_o` is high, `bp_f0_n` is low, `bp_oe` is low, and `rd_data` is 0.
- R2: Let c be the number of master cycles since the frame boundary (c = 0 at the boundary). With default polarity, `clk8_o` = bit 0 of c, `clk4_o` = bit 1 of c and `clk2_o` = bit 2 of c. `bp_c4` and `bp_c2` equal bits 1 and 2 of c at all times.
- R3: The frame lasts 2048 master cycles. `frame_o` (default polarity) is high and `bp_f0_n` is low for four cycles: c = 2046, 2047, 0 and 1.
- R4: Configuration bits [3:0] invert the outputs when set: bit 0 inverts `frame_o`, bit 1 inverts `clk2_o`, bit 2 inverts `clk4_o` and bit 3 inverts `clk8_o`. The change takes effect in the cycle after the write. The backplane outputs are never inverted.
- R5: Configuration bit 4 (master enable) drives `bp_oe` from the cycle after the write.
- R6: Configuration bit 5 enables synchronized mode. While it is 0, reference edges leave the frame phase unchanged.
- R7: Configuration bit 6 selects the reference: 0 selects `ref_a` and 1 selects `ref_b`. Edges on the unselected reference leave the frame phase unchanged.
- R8: In synchronized mode, a rising edge of the selected reference is detected one cycle after the second clock edge that samples it high. The master cycle in which the edge is detected becomes c = 0.
- R9: If the edge is detected while the counter is already at c = 2047, 0 or 1, the counter does not jump.
- R10: `rd_data[6:0]` returns the configuration and `rd_data[7]` reads 0. `rd_data[11:8]` return the levels of `ref_a`, `ref_b`, `ack0_in` and `ack1_in` in that order, through two synchronizer flops, so a pin change shows after the second clock edge.
- R11: Writes load `wr_data[6:0]` on the clock edge where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration write data |
| rd_data | output | 12 | Configuration and pin-level readback |
| ref_a | input | 1 | External 8 kHz reference A |
| ref_b | input | 1 | External 8 kHz reference B |
| ack0_in | input | 1 | Status input pin 0 |
| ack1_in | input | 1 | Status input pin 1 |
| frame_o | output | 1 | Local frame pulse, polarity programmable |
| clk2_o | output | 1 | Local 2.048 MHz clock, polarity programmable |
| clk4_o | output | 1 | Local 4.096 MHz clock, polarity programmable |
| clk8_o | output | 1 | Local 8.192 MHz clock, polarity programmable |
| bp_f0_n | output | 1 | Backplane active-low frame strobe |
| bp_c2 | output | 1 | Backplane 2.048 MHz clock |
| bp_c4 | output | 1 | Backplane 4.096 MHz clock |
| bp_oe | output | 1 | Backplane drive enable (master mode) |

## Verification
Several properties are checked on every cycle:
- the edge detector never fires twice in a row;
- an edge detected inside the tolerance window never makes the counter jump;
- any realignment leaves the counter within two counts of the boundary;
- the master-enable bit follows a write.

Only the bench scenarios can show the rest. These cover the exact cycle a reference edge becomes the boundary, the frame period and pulse width seen at the pins, that polarity applies per output, and that the unselected reference and disabled synchronization are both ignored.

// File: rtl/tdm_clkgen_pkg.sv
// Package: shared configuration layout for the TDM clock generator.
// Assumes the configuration word is 7 bits, most significant field first.
package tdm_clkgen_pkg;

    typedef struct packed {
        logic ref_b_sel;   // [6]
        logic sync_en;     // [5]
        logic master_en;   // [4]
        logic inv_clk8;    // [3]
        logic inv_clk4;    // [2]
        logic inv_clk2;    // [1]
        logic inv_frame;   // [0]
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/tdm_cfg_regs.sv
// Configuration register and pin-level readback.
// Assumes pins are asynchronous; SYNC_DEPTH >= 2 flops are used on them.
module tdm_cfg_regs
    import tdm_clkgen_pkg::*;
#(
    parameter int SYNC_DEPTH = 2,
    parameter int PIN_N      = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [7:0]               wr_data,
    input  logic [PIN_N-1:0]         pins,
    output cfg_t                     cfg,
    output logic [PIN_N+7:0]         rd_data
);
    localparam int SR_W = SYNC_DEPTH * PIN_N;

    logic [SR_W-1:0] pin_sr;

    // Holds the configuration word; loaded on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg <= '0;
        else if (wr_en) cfg <= cfg_t'(wr_data[CFG_W-1:0]);
    end

    // Synchronizes the status pins into the master clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_sr <= '0;
        else        pin_sr <= {pin_sr[SR_W-PIN_N-1:0], pins};
    end

    // Assembles the readback word.
    always_comb rd_data = {pin_sr[SR_W-1 -: PIN_N], 1'b0, cfg};

    AST_MASTER_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg.master_en == $past(wr_data[4])); // R5

endmodule

// File: rtl/tdm_ref_edge.sv
// Synchronizes both external references, selects one, and emits a
// one-cycle pulse on its rising edge. Assumes SYNC_DEPTH >= 2.
module tdm_ref_edge #(
    parameter int SYNC_DEPTH = 2,
    parameter int REF_N      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_N-1:0] refs,
    input  logic             sel_b,
    output logic             edge_pulse
);
    logic [REF_N-1:0] ref_s;
    logic             sel_lvl;
    logic             sel_prev;

    for (genvar i = 0; i < REF_N; i++) begin : g_sync
        logic [SYNC_DEPTH-1:0] sr;
        // Shifts one reference through its synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[SYNC_DEPTH-2:0], refs[i]};
        end
        assign ref_s[i] = sr[SYNC_DEPTH-1];
    end

    // Picks the reference the configuration selects.
    always_comb sel_lvl = sel_b ? ref_s[1] : ref_s[0];

    // Remembers the previous selected level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_prev <= 1'b0;
        else        sel_prev <= sel_lvl;
    end

    // Flags the first cycle the selected level is high.
    always_comb edge_pulse = sel_lvl & ~sel_prev;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse); // R8

endmodule

// File: rtl/tdm_frame_cnt.sv
// Frame counter: wraps every 2**CNT_W master cycles and, on a realign
// request, moves its phase so the request cycle counts as 0, unless it is
// already within one count of the boundary.
module tdm_frame_cnt #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             realign,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);
    localparam logic [CNT_W-1:0] LAST = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic near;

    // Detects a counter already within one count of the boundary.
    always_comb near = (cnt_q == LAST) || (cnt_q <= ONE);

    // Chooses between a phase jump and a normal increment.
    always_comb begin
        if (realign && !near) cnt_d = ONE;
        else                  cnt_d = cnt_q + ONE;
    end

    // Holds the frame phase.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_NO_JUMP_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (realign && near) |=> cnt_q == $past(cnt_q) + ONE); // R9

    AST_REALIGN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> cnt_q <= CNT_W'(2)); // R8

endmodule

// File: rtl/tdm_clk_out.sv
// Output stage: registers the clock bits and the frame window from the next
// counter value, so the registered outputs match the counter in the same
// cycle without decode glitches. Polarity is applied after the registers.
module tdm_clk_out
    import tdm_clkgen_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_d,
    input  cfg_t             cfg,
    output logic             frame_o,
    output logic             clk2_o,
    output logic             clk4_o,
    output logic             clk8_o,
    output logic             bp_f0_n,
    output logic             bp_c2,
    output logic             bp_c4,
    output logic             bp_oe
);
    localparam logic [CNT_W-1:0] LAST   = '1;
    localparam logic [CNT_W-1:0] WIN_LO = LAST - CNT_W'(1);
    localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(1);

    logic frame_r, c2_r, c4_r, c8_r;
    logic frame_hit;

    // Marks the four-cycle window centred on the frame boundary.
    always_comb frame_hit = (cnt_d >= WIN_LO) || (cnt_d <= WIN_HI);

    // Registers raw clock and frame levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_r <= 1'b1;
            c2_r    <= 1'b0;
            c4_r    <= 1'b0;
            c8_r    <= 1'b0;
        end else begin
            frame_r <= frame_hit;
            c2_r    <= cnt_d[2];
            c4_r    <= cnt_d[1];
            c8_r    <= cnt_d[0];
        end
    end

    // Applies per-output polarity and drives the backplane copies.
    always_comb begin
        frame_o = frame_r ^ cfg.inv_frame;
        clk2_o  = c2_r ^ cfg.inv_clk2;
        clk4_o  = c4_r ^ cfg.inv_clk4;
        clk8_o  = c8_r ^ cfg.inv_clk8;
        bp_f0_n = ~frame_r;
        bp_c2   = c2_r;
        bp_c4   = c4_r;
        bp_oe   = cfg.master_en;
    end

endmodule

// File: rtl/tdm_clkgen.sv
// Top: TDM frame and bit clock generator with optional realignment to an
// external 8 kHz reference. Assumes clk is the 16.384 MHz master clock.
module tdm_clkgen
    import tdm_clkgen_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int SYNC_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [11:0] rd_data,
    input  logic        ref_a,
    input  logic        ref_b,
    input  logic        ack0_in,
    input  logic        ack1_in,
    output logic        frame_o,
    output logic        clk2_o,
    output logic        clk4_o,
    output logic        clk8_o,
    output logic        bp_f0_n,
    output logic        bp_c2,
    output logic        bp_c4,
    output logic        bp_oe
);
    cfg_t             cfg;
    logic             edge_pulse;
    logic             realign;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    tdm_cfg_regs #(.SYNC_DEPTH(SYNC_DEPTH), .PIN_N(4)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pins    ({ack1_in, ack0_in, ref_b, ref_a}),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    tdm_ref_edge #(.SYNC_DEPTH(SYNC_DEPTH), .REF_N(2)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .refs       ({ref_b, ref_a}),
        .sel_b      (cfg.ref_b_sel),
        .edge_pulse (edge_pulse)
    );

    // Gates realignment by the synchronized-mode bit.
    always_comb realign = edge_pulse & cfg.sync_en;

    tdm_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .realign (realign),
        .cnt_q   (cnt_q),
        .cnt_d   (cnt_d)
    );

    tdm_clk_out #(.CNT_W(CNT_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_d   (cnt_d),
        .cfg     (cfg),
        .frame_o (frame_o),
        .clk2_o  (clk2_o),
        .clk4_o  (clk4_o),
        .clk8_o  (clk8_o),
        .bp_f0_n (bp_f0_n),
        .bp_c2   (bp_c2),
        .bp_c4   (bp_c4),
        .bp_oe   (bp_oe)
    );

    AST_FREE_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !realign |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R6

endmodule

// File: tb/tdm_clkgen_tb.sv
`timescale 1ns/1ps
module tdm_clkgen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [11:0] rd_data;
    logic        ref_a = 1'b0, ref_b = 1'b0, ack0_in = 1'b0, ack1_in = 1'b0;
    logic        frame_o, clk2_o, clk4_o, clk8_o, bp_f0_n, bp_c2, bp_c4, bp_oe;

    int checks = 0;
    int failures = 0;
    int raw = 0;       // cycles since reset, bench-owned
    int ofs = 0;       // phase offset set by expected realignments
    logic [3:0] inv = '0;

    always #2 clk = ~clk;

    tdm_clkgen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ref_a(ref_a), .ref_b(ref_b),
        .ack0_in(ack0_in), .ack1_in(ack1_in),
        .frame_o(frame_o), .clk2_o(clk2_o), .clk4_o(clk4_o), .clk8_o(clk8_o),
        .bp_f0_n(bp_f0_n), .bp_c2(bp_c2), .bp_c4(bp_c4), .bp_oe(bp_oe)
    );

    // Bench cycle count since reset
    always @(posedge clk) begin
        if (!rst_n) raw <= 0;
        else        raw <= raw + 1;
    end

    function automatic int ph();
        return (raw - ofs) & 2047;
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] expected_outs();
        int p = ph();
        logic fr = (p >= 2046) || (p <= 1);
        return {fr ^ inv[0], p[2] ^ inv[1], p[1] ^ inv[2], p[0] ^ inv[3],
                ~fr, p[2], p[1]};
    endfunction

    // Compares all clock outputs against the phase model for n cycles
    task automatic check_outputs(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({9'd0, frame_o, clk2_o, clk4_o, clk8_o, bp_f0_n, bp_c2, bp_c4},
                {9'd0, expected_outs()}, req);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        inv = v[3:0];
    endtask

    // Raises a reference in the cycle where the model is at phase p
    task automatic drive_ref(input bit use_b, input int p, input bit jump, input string req);
        do @(negedge clk); while (ph() != p);
        if (use_b) ref_b = 1'b1; else ref_a = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        if (jump) ofs = raw;   // detection cycle becomes phase 0
        check_outputs(24, req);
        ref_a = 1'b0; ref_b = 1'b0;
        check_outputs(8, req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({11'd0, frame_o, clk2_o, clk4_o, clk8_o, bp_f0_n},
            {11'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, "R1 outputs");
        chk({15'd0, bp_oe}, 16'd0, "R1 bp_oe");
        chk({4'd0, rd_data}, 16'd0, "R1 rd_data");
        rst_n = 1'b1;
    endtask

    task automatic t_free_run();
        check_outputs(16, "R2 clock bits");
        check_outputs(2100, "R3 frame period");
    endtask

    task automatic t_polarity();
        wr(8'h0F);
        check_outputs(20, "R4 all inverted");
        wr(8'h05);
        do @(negedge clk); while (ph() != 2040);
        check_outputs(16, "R4 mixed polarity");
        wr(8'h00);
        check_outputs(4, "R4 restore");
    endtask

    task automatic t_master();
        wr(8'h10);
        chk({15'd0, bp_oe}, 16'd1, "R5 master on");
        chk({4'd0, rd_data}, 16'h010, "R11 readback cfg");
        wr(8'h00);
        chk({15'd0, bp_oe}, 16'd0, "R5 master off");
    endtask

    task automatic t_readback();
        @(negedge clk);
        ack0_in = 1'b1; ack1_in = 1'b1; ref_b = 1'b1;
        @(posedge clk); @(negedge clk);
        chk({4'd0, rd_data}, 16'h000, "R10 latency");
        @(posedge clk); @(negedge clk);
        chk({4'd0, rd_data}, 16'hE00, "R10 pin levels");
        ack0_in = 1'b0; ack1_in = 1'b0; ref_b = 1'b0;
        repeat (3) @(negedge clk);
        chk({4'd0, rd_data}, 16'h000, "R10 pins low");
    endtask

    task automatic t_sync_off();
        drive_ref(1'b0, 1000, 1'b0, "R6 sync disabled ignores ref");
    endtask

    task automatic t_align();
        wr(8'h20);
        drive_ref(1'b0, 700, 1'b1, "R8 realign to ref A");
        check_outputs(2050, "R8 frame after realign");
    endtask

    task automatic t_tolerance();
        drive_ref(1'b0, 2045, 1'b0, "R9 edge at 2047");
        drive_ref(1'b0, 2046, 1'b0, "R9 edge at 0");
        drive_ref(1'b0, 2047, 1'b0, "R9 edge at 1");
        drive_ref(1'b0, 2044, 1'b1, "R9 edge at 2046 jumps");
        drive_ref(1'b0, 0, 1'b1, "R9 edge at 2 jumps");
    endtask

    task automatic t_select();
        wr(8'h60);
        drive_ref(1'b0, 300, 1'b0, "R7 ref A ignored when B selected");
        drive_ref(1'b1, 900, 1'b1, "R7 realign to ref B");
        wr(8'h20);
        drive_ref(1'b1, 500, 1'b0, "R7 ref B ignored when A selected");
    endtask

    initial begin
        t_reset();
        t_free_run();
        t_polarity();
        t_master();
        t_readback();
        t_sync_off();
        t_align();
        t_tolerance();
        t_select();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #600000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule